// File: doc/BRIEF.md
# Four-Value Ascending Sorter

A pipelined sorting unit that accepts four unsigned 8-bit values on every clock and, two clock edges later, presents the same four values in ascending order: the smallest on the first output lane and the largest on the fourth. It is meant to sit inline in a streaming datapath. One set can enter per cycle, and a valid flag travels with each set through the pipe.

The first stage evaluates all six pairwise magnitude comparisons at once. From them it derives a rank for each input, which is the number of other inputs that must precede it. The rank is turned into a 2-bit source index for every output lane. These indices are registered together with a copy of the raw inputs. The second stage feeds each lane from a 4:1 multiplexer steered by the registered index and registers the result. When two inputs are equal, the one on the lower-numbered lane counts as smaller. This keeps the four indices a true permutation.

Top module: `quad_sort4`

## Requirements
- R1: Whenever `vld_o` is high, `out0 <= out1 <= out2 <= out3` holds.
- R2: A set whose `vld_i` is high appears on the outputs as exactly the same multiset of four values, with nothing duplicated or dropped.
- R3: `vld_o` is high in the cycle following the second rising edge after the cycle in which `vld_i` was high for that set. It is low in every other cycle (latency of two clocks).
- R4: A new set may be presented on every cycle. Back-to-back sets come out on consecutive cycles in the order they went in.
- R5: Equal inputs are ordered by lane number, with lane 0 first and lane 3 last. The registered source indices form a permutation of 0..3, so repeated values appear exactly as many times as they were presented.
- R6: While `rst_n` is low, and after its release until the first set has passed through, `vld_o` is 0 and all four outputs are 0.
- R7: In any cycle where `vld_o` is low, the four outputs keep the values of the most recent sorted set (or 0 if none yet). Inputs presented with `vld_i` low have no effect on them.
- R8: Comparison is unsigned. For example, 8'h80 and 8'hFF sort above 8'h7F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| vld_i | input | 1 | Marks the current four inputs as a set to sort |
| in0 | input | 8 | Input lane 0 |
| in1 | input | 8 | Input lane 1 |
| in2 | input | 8 | Input lane 2 |
| in3 | input | 8 | Input lane 3 |
| vld_o | output | 1 | Marks the outputs as a sorted set |
| out0 | output | 8 | Smallest value |
| out1 | output | 8 | Second smallest value |
| out2 | output | 8 | Second largest value |
| out3 | output | 8 | Largest value |

## Verification
Four properties run on every cycle. The assertions check that a valid output set is non-decreasing across lanes and that the registered source indices are pairwise distinct. They also check that the output flag repeats the input flag two edges later, and that the outputs do not move in a cycle with no valid set. The scoreboard bench is the only place some behaviours can be seen. It shows that each set comes out as the same multiset it went in as, and that back-to-back sets stay in order. Its scenarios also cover tied values appearing the right number of times, the unsigned treatment of values with the top bit set, and the zeroed outputs around reset.

// File: rtl/sort4_pkg.sv
package sort4_pkg;
  localparam int NUM_LANES = 4;
  localparam int SEL_W     = $clog2(NUM_LANES);

  typedef logic [SEL_W-1:0] sel_t;
  typedef logic [NUM_LANES-1:0][NUM_LANES-1:0] order_mat_t;
endpackage

// File: rtl/s4_pair_cmp.sv
// All pairwise comparisons in parallel. after_o[i][j] = 1 means lane i
// must be placed after lane j. Only pairs with i > j own a comparator;
// the mirrored entry is its complement, which encodes the lane tie-break.
module s4_pair_cmp
  import sort4_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [NUM_LANES-1:0][DATA_W-1:0] data_i,
  output order_mat_t                       after_o
);

  always_comb begin
    after_o = '0;
    for (int i = 0; i < NUM_LANES; i++) begin
      for (int j = 0; j < i; j++) begin
        // higher lane follows lower lane when greater or equal (tie -> lane order)
        after_o[i][j] = (data_i[i] >= data_i[j]);
        after_o[j][i] = ~(data_i[i] >= data_i[j]);
      end
    end
  end

endmodule

// File: rtl/s4_rank_select.sv
// Turns the order matrix into a rank per lane, then finds for every output
// position the lane whose rank equals that position.
module s4_rank_select
  import sort4_pkg::*;
(
  input  order_mat_t               after_i,
  output sel_t [NUM_LANES-1:0]     sel_o
);

  sel_t [NUM_LANES-1:0] rank_w;

  always_comb begin
    for (int i = 0; i < NUM_LANES; i++) begin
      rank_w[i] = '0;
      for (int j = 0; j < NUM_LANES; j++) begin
        rank_w[i] = rank_w[i] + sel_t'(after_i[i][j]);
      end
    end
  end

  always_comb begin
    for (int k = 0; k < NUM_LANES; k++) begin
      sel_o[k] = '0;
      for (int i = 0; i < NUM_LANES; i++) begin
        if (rank_w[i] == sel_t'(k)) begin
          sel_o[k] = sel_t'(i);
        end
      end
    end
  end

endmodule

// File: rtl/s4_out_mux.sv
// One 4:1 multiplexer per output position, steered by a registered index.
module s4_out_mux
  import sort4_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [NUM_LANES-1:0][DATA_W-1:0] data_i,
  input  sel_t [NUM_LANES-1:0]             sel_i,
  output logic [NUM_LANES-1:0][DATA_W-1:0] data_o
);

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane_mux
    always_comb begin
      data_o[k] = '0;
      for (int i = 0; i < NUM_LANES; i++) begin
        if (sel_i[k] == sel_t'(i)) begin
          data_o[k] = data_i[i];
        end
      end
    end
  end

endmodule

// File: rtl/quad_sort4.sv
module quad_sort4
  import sort4_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] in0,
  input  logic [DATA_W-1:0] in1,
  input  logic [DATA_W-1:0] in2,
  input  logic [DATA_W-1:0] in3,
  output logic              vld_o,
  output logic [DATA_W-1:0] out0,
  output logic [DATA_W-1:0] out1,
  output logic [DATA_W-1:0] out2,
  output logic [DATA_W-1:0] out3
);

  localparam int WARM_W = 2;

  typedef logic [NUM_LANES-1:0][DATA_W-1:0] lanes_t;

  lanes_t               din_w;
  order_mat_t           after_w;
  sel_t [NUM_LANES-1:0] sel_w;

  // stage 1 state
  logic                 s1_vld_q, s1_vld_d;
  lanes_t               s1_data_q, s1_data_d;
  sel_t [NUM_LANES-1:0] s1_sel_q, s1_sel_d;

  // stage 2 state
  logic                 s2_vld_q, s2_vld_d;
  lanes_t               s2_mux_w;
  lanes_t               s2_data_q, s2_data_d;

  // edges since reset release, used only to open the latency check window
  logic [WARM_W-1:0]    warm_q, warm_d;

  assign din_w = {in3, in2, in1, in0};

  s4_pair_cmp #(.DATA_W(DATA_W)) u_cmp (
    .data_i  (din_w),
    .after_o (after_w)
  );

  s4_rank_select u_rank (
    .after_i (after_w),
    .sel_o   (sel_w)
  );

  s4_out_mux #(.DATA_W(DATA_W)) u_mux (
    .data_i (s1_data_q),
    .sel_i  (s1_sel_q),
    .data_o (s2_mux_w)
  );

  // next-state logic, clock enables written out
  always_comb begin
    s1_vld_d  = vld_i;
    s1_data_d = s1_data_q;
    s1_sel_d  = s1_sel_q;
    if (vld_i) begin
      s1_data_d = din_w;
      s1_sel_d  = sel_w;
    end

    s2_vld_d  = s1_vld_q;
    s2_data_d = s2_data_q;
    if (s1_vld_q) begin
      s2_data_d = s2_mux_w;
    end

    warm_d = warm_q;
    if (warm_q != {WARM_W{1'b1}}) begin
      warm_d = warm_q + WARM_W'(1);
    end
  end

  // control and output registers with reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q  <= 1'b0;
      s2_vld_q  <= 1'b0;
      s2_data_q <= '0;
      warm_q    <= '0;
    end else begin
      s1_vld_q  <= s1_vld_d;
      s2_vld_q  <= s2_vld_d;
      s2_data_q <= s2_data_d;
      warm_q    <= warm_d;
    end
  end

  // stage 1 data registers need no reset
  always_ff @(posedge clk) begin
    s1_data_q <= s1_data_d;
    s1_sel_q  <= s1_sel_d;
  end

  assign vld_o = s2_vld_q;
  assign out0  = s2_data_q[0];
  assign out1  = s2_data_q[1];
  assign out2  = s2_data_q[2];
  assign out3  = s2_data_q[3];

  AST_ORDERED_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> ((out0 <= out1) && (out1 <= out2) && (out2 <= out3))); // R1

  AST_SEL_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld_q |-> ((s1_sel_q[0] != s1_sel_q[1]) && (s1_sel_q[0] != s1_sel_q[2]) &&
                  (s1_sel_q[0] != s1_sel_q[3]) && (s1_sel_q[1] != s1_sel_q[2]) &&
                  (s1_sel_q[1] != s1_sel_q[3]) && (s1_sel_q[2] != s1_sel_q[3]))); // R5

  AST_TWO_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q >= WARM_W'(2)) |-> (vld_o == $past(vld_i, 2))); // R3

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_o |-> ($stable(out0) && $stable(out1) && $stable(out2) && $stable(out3))); // R7

endmodule

// File: tb/tb_quad_sort4.sv
module tb_quad_sort4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       vld_i;
  logic [7:0] in0, in1, in2, in3;
  logic       vld_o;
  logic [7:0] out0, out1, out2, out3;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit have_last = 1'b0;
  logic [31:0] last_exp = '0;

  logic [31:0] exp_q[$];
  int          cyc_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  quad_sort4 #(.DATA_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .vld_i(vld_i),
    .in0(in0), .in1(in1), .in2(in2), .in3(in3),
    .vld_o(vld_o), .out0(out0), .out1(out1), .out2(out2), .out3(out3)
  );

  // independent reference: simple insertion sort, lane k of result in bits [8k+:8]
  function automatic logic [31:0] ref_sort(input logic [7:0] a, b, c, d);
    logic [7:0] v[4];
    logic [7:0] t;
    v[0] = a; v[1] = b; v[2] = c; v[3] = d;
    for (int i = 1; i < 4; i++) begin
      for (int j = i; j > 0; j--) begin
        if (v[j] < v[j-1]) begin
          t = v[j]; v[j] = v[j-1]; v[j-1] = t;
        end
      end
    end
    return {v[3], v[2], v[1], v[0]};
  endfunction

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic drive_set(input logic [7:0] a, b, c, d, input string tag);
    @(posedge clk); #2;
    vld_i = 1'b1; in0 = a; in1 = b; in2 = c; in3 = d;
    exp_q.push_back(ref_sort(a, b, c, d));
    cyc_q.push_back(cyc);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      vld_i = 1'b0;
      in0 = 8'($urandom); in1 = 8'($urandom); in2 = 8'($urandom); in3 = 8'($urandom);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (vld_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected valid output", {out3, out2, out1, out0}, 32'h0);
        end else begin
          logic [31:0] e;
          int          c0;
          string       tg;
          e  = exp_q.pop_front();
          c0 = cyc_q.pop_front();
          tg = tag_q.pop_front();
          check({out3, out2, out1, out0} == e, {tg, " sorted set"}, {out3, out2, out1, out0}, e);
          check(cyc == c0 + 2, "R3 latency", 32'(cyc - c0), 32'd2);
          last_exp  = e;
          have_last = 1'b1;
        end
      end else begin
        // R7 idle cycles hold the last sorted set (R6: zero before any set)
        check({out3, out2, out1, out0} == (have_last ? last_exp : 32'h0),
              have_last ? "R7 hold while idle" : "R6 zero after reset",
              {out3, out2, out1, out0}, have_last ? last_exp : 32'h0);
      end
    end
  end

  initial begin
    rst_n = 1'b0; vld_i = 1'b0;
    in0 = 8'h11; in1 = 8'h22; in2 = 8'h33; in3 = 8'h44;
    repeat (3) @(negedge clk);
    // R6 reset state, with inputs toggling under reset
    vld_i = 1'b1;
    @(negedge clk);
    check(vld_o == 1'b0, "R6 vld_o in reset", 32'(vld_o), 32'h0);
    check({out3, out2, out1, out0} == 32'h0, "R6 outputs in reset", {out3, out2, out1, out0}, 32'h0);
    vld_i = 1'b0;
    @(posedge clk); #2 rst_n = 1'b1;
    idle(3);

    drive_set(8'd1, 8'd2, 8'd3, 8'd4, "R1 ascending input");
    idle(2);
    drive_set(8'd200, 8'd150, 8'd90, 8'd7, "R2 descending input");
    drive_set(8'd40, 8'd9, 8'd77, 8'd12, "R2 mixed input");
    idle(3);
    drive_set(8'd5, 8'd5, 8'd5, 8'd5, "R5 all equal");
    drive_set(8'd9, 8'd3, 8'd9, 8'd3, "R5 two tied pairs");
    drive_set(8'd60, 8'd60, 8'd2, 8'd99, "R5 one tie");
    idle(2);
    drive_set(8'h7F, 8'h80, 8'h00, 8'hFF, "R8 unsigned extremes");
    drive_set(8'hFE, 8'h01, 8'hFF, 8'h7F, "R8 top bit set");
    idle(4);

    // R4 back-to-back stream, narrow range forces many ties
    for (int n = 0; n < 60; n++) begin
      drive_set(8'($urandom_range(0, 3)), 8'($urandom_range(0, 3)),
                8'($urandom), 8'($urandom_range(250, 255)), "R4 back-to-back");
    end
    idle(3);
    for (int n = 0; n < 80; n++) begin
      drive_set(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), "R2 random");
      if (n % 3 == 0) idle(1 + (n % 4));
    end
    idle(6);

    check(exp_q.size() == 0, "R2 all sets delivered", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired: R3 run did not complete actual=%0d expected=%0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule